// File: doc/BRIEF.md
# Double-Buffered Pixel Color Matrix

This block converts every pixel of a stream from one color space to another. Each of the three output components is formed as a weighted sum of the three input components plus a constant: out_r = k_r1*x + k_r2*y + k_r3*z + k_r4. The weights and constants come from one of two programmable coefficient banks, or from a fixed built-in matrix. In bypass the pixel passes through unchanged.

Software loads the bank that is not in use while the other bank keeps converting pixels. It then writes a new mode into the control word. The new mode is held as pending and takes effect at the next frame-start strobe, so every frame is converted with a single matrix. The pixel stream is qualified by a valid bit. The datapath has a fixed three-cycle latency in every mode.

Top module: `pix_matrix_csc`

## Requirements
- R1: While reset is held and on the first cycle after it, `pix_out_valid` is 0. The reset mode is bypass, both banks are zero, and the pending mode is bypass.
- R2: In mode codes 0, 1, 6 and 7, `pix_out` equals `pix_in`, bit for bit.
- R3: `pix_out_valid` repeats `pix_in_valid` exactly three clock cycles later in every mode, including when valid has gaps.
- R4: Register map:
  - Addresses 0 to 5 hold bank A and addresses 8 to 13 hold bank B.
  - Word k of a bank carries coefficient 2k in bits [15:0] and coefficient 2k+1 in bits [31:16].
  - Coefficients are numbered row*4 + column (rows 0 to 2, columns 0 to 3).
  - Address 6 is the control word, with the mode in bits [2:0].
  - Pixel components are packed as x in [11:0], y in [23:12] and z in [35:24]. Output row r sits at [12r+11:12r].
- R5: Mode 4 converts with bank A. A bank holding 0x2000 on the diagonal and zeros elsewhere passes every pixel through unchanged.
- R6: Mode 5 converts with bank B.
- R7: Number formats and arithmetic:
  - Columns 0 to 2 are signed with 13 fraction bits.
  - Column 3 is a signed offset with 13 fraction bits, counted in units of full scale (4096 codes).
  - The exact sum is rounded to nearest, with halves going up, then clamped to 0..4095.
- R8: Mode 2 uses a built-in RGB-to-YCbCr 601 matrix. Its rows are (2449, 4809, 934, 0), (-1382, -2714, 4096, 4096) and (4096, -3430, -666, 4096).
- R9: Mode 3 uses a built-in RGB-to-YCbCr 709 matrix. Its rows are (1742, 5859, 591, 0), (-939, -3157, 4096, 4096) and (4096, -3720, -376, 4096).
- R10: A control write only changes the pending mode. The active mode takes the pending value on a cycle with `frame_start` high, and the pixel presented in that cycle already uses the new mode.
- R11: Loading the inactive bank does not change the output of the active bank, and a bank keeps its contents while the other one is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start strobe; applies the pending mode |
| pix_in_valid | input | 1 | Input pixel qualifier |
| pix_in | input | 36 | Input pixel, three 12-bit components |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 36 | Converted pixel, three 12-bit components |

## Verification
Each row of one bank is swept over all 4096 values of x. That bank drives one row into both clamps (2x - 0.5 full scale) and puts another exactly on the 4096 overflow edge (1.0 - x). A third row averages two components so that every odd sum lands on a rounding half. A design that truncated or wrapped instead of saturating would show up as wrong codes at the ends of these sweeps. Bank switches are tested with the bank already loaded but no strobe, then with the strobe on the first pixel. A design that switched at once, one pixel late, or mixed up the word halves of the two banks would give the wrong matrix on those pixels. Modes 1, 6 and 7 are each checked as bypass, and valid gaps are checked against the three-cycle latency.

// File: rtl/pix_csc_pkg.sv
package pix_csc_pkg;

  localparam int ROWS  = 3;
  localparam int COLS  = 4;
  localparam int NCOEF = ROWS * COLS;
  localparam int BI_W  = 16;

  localparam logic [2:0] MODE_BYPASS = 3'd0;
  localparam logic [2:0] MODE_601    = 3'd2;
  localparam logic [2:0] MODE_709    = 3'd3;
  localparam logic [2:0] MODE_BANK_A = 3'd4;
  localparam logic [2:0] MODE_BANK_B = 3'd5;

  // Fixed RGB to YCbCr sets, 13 fraction bits, index = row*COLS + col
  function automatic logic [NCOEF*BI_W-1:0] builtin_set(input logic use709);
    int k [NCOEF];
    logic [NCOEF*BI_W-1:0] v;
    if (use709)
      k = '{1742, 5859, 591, 0, -939, -3157, 4096, 4096, 4096, -3720, -376, 4096};
    else
      k = '{2449, 4809, 934, 0, -1382, -2714, 4096, 4096, 4096, -3430, -666, 4096};
    for (int i = 0; i < NCOEF; i++) v[i*BI_W +: BI_W] = k[i][BI_W-1:0];
    return v;
  endfunction

  function automatic logic mode_is_bypass(input logic [2:0] m);
    return !(m == MODE_601 || m == MODE_709 || m == MODE_BANK_A || m == MODE_BANK_B);
  endfunction

endpackage

// File: rtl/csc_coef_banks.sv
module csc_coef_banks #(
  parameter int COEF_W = 16,
  parameter int ADDR_W = 4,
  parameter int NCOEF  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [2*COEF_W-1:0]     wdata,
  output logic [NCOEF*COEF_W-1:0] coefs_a,
  output logic [NCOEF*COEF_W-1:0] coefs_b
);
  localparam int WORDS = NCOEF / 2;

  logic [2*COEF_W-1:0] mem_a [WORDS];
  logic [2*COEF_W-1:0] mem_b [WORDS];

  logic              bank_sel;
  logic [ADDR_W-2:0] widx;
  logic              hit;

  assign bank_sel = addr[ADDR_W-1];
  assign widx     = addr[ADDR_W-2:0];
  assign hit      = we && (int'(widx) < WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) begin
        mem_a[w] <= '0;
        mem_b[w] <= '0;
      end
    end else if (hit) begin
      if (bank_sel) mem_b[widx] <= wdata;
      else          mem_a[widx] <= wdata;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_unpack
    assign coefs_a[(2*w)*COEF_W   +: COEF_W] = mem_a[w][COEF_W-1:0];
    assign coefs_a[(2*w+1)*COEF_W +: COEF_W] = mem_a[w][2*COEF_W-1:COEF_W];
    assign coefs_b[(2*w)*COEF_W   +: COEF_W] = mem_b[w][COEF_W-1:0];
    assign coefs_b[(2*w+1)*COEF_W +: COEF_W] = mem_b[w][2*COEF_W-1:COEF_W];
  end

endmodule

// File: rtl/csc_mode_ctrl.sv
module csc_mode_ctrl #(
  parameter int ADDR_W = 4,
  parameter int CTRL_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        mode_wdata,
  input  logic              frame_start,
  output logic [2:0]        pend_mode,
  output logic [2:0]        act_mode,
  output logic [2:0]        eff_mode
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  // The pixel that arrives with the strobe already uses the pending mode
  assign eff_mode = frame_start ? pend_mode : act_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= 3'd0;
      act_mode  <= 3'd0;
    end else begin
      if (we && addr == CTRL_A) pend_mode <= mode_wdata;
      act_mode <= eff_mode;
    end
  end

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13,
  parameter int ROWS   = 3,
  parameter int COLS   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [ROWS*PIX_W-1:0]       in_pix,
  input  logic [ROWS*COLS*COEF_W-1:0] coefs,
  input  logic                        bypass,
  output logic                        out_valid,
  output logic [ROWS*PIX_W-1:0]       out_pix
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(COLS) + 1;
  localparam int MAXV   = (1 << PIX_W) - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

  logic                  v1_q, v2_q, v3_q;
  logic                  byp1_q, byp2_q;
  logic [ROWS*PIX_W-1:0] pix1_q, pix2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    byp1_q <= bypass;
    byp2_q <= byp1_q;
    pix1_q <= in_pix;
    pix2_q <= pix1_q;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [PROD_W-1:0] prod_q [ROWS];
    logic signed [ACC_W-1:0]  off_q;
    logic signed [ACC_W-1:0]  sum_d, sum_q;
    logic signed [ACC_W-1:0]  rnd, shf;
    logic [PIX_W-1:0]         sat, res_q;
    logic [COEF_W-1:0]        off_c;

    // stage 1: products and scaled offset
    for (genvar c = 0; c < ROWS; c++) begin : g_mul
      always_ff @(posedge clk)
        prod_q[c] <= $signed(coefs[(r*COLS+c)*COEF_W +: COEF_W]) *
                     $signed({1'b0, in_pix[c*PIX_W +: PIX_W]});
    end

    assign off_c = coefs[(r*COLS+COLS-1)*COEF_W +: COEF_W];
    always_ff @(posedge clk)
      off_q <= {{(ACC_W-COEF_W-PIX_W){off_c[COEF_W-1]}}, off_c, {PIX_W{1'b0}}};

    // stage 2: full precision sum
    always_comb begin
      sum_d = off_q;
      for (int c = 0; c < ROWS; c++) sum_d = sum_d + ACC_W'(prod_q[c]);
    end
    always_ff @(posedge clk) sum_q <= sum_d;

    // stage 3: round half up, clamp
    always_comb begin
      rnd = sum_q + HALF;
      shf = rnd >>> FRAC;
      if (shf < 0)          sat = '0;
      else if (shf > MAXV)  sat = PIX_W'(MAXV);
      else                  sat = shf[PIX_W-1:0];
    end
    always_ff @(posedge clk)
      res_q <= byp2_q ? pix2_q[r*PIX_W +: PIX_W] : sat;

    assign out_pix[r*PIX_W +: PIX_W] = res_q;
  end

  assign out_valid = v3_q;

endmodule

// File: rtl/pix_matrix_csc.sv
module pix_matrix_csc
  import pix_csc_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [2*COEF_W-1:0]    reg_wdata,
  input  logic                   frame_start,
  input  logic                   pix_in_valid,
  input  logic [ROWS*PIX_W-1:0]  pix_in,
  output logic                   pix_out_valid,
  output logic [ROWS*PIX_W-1:0]  pix_out
);
  localparam int SET_W = NCOEF * COEF_W;
  localparam logic [NCOEF*BI_W-1:0] BI601 = builtin_set(1'b0);
  localparam logic [NCOEF*BI_W-1:0] BI709 = builtin_set(1'b1);

  logic [SET_W-1:0] coefs_a, coefs_b, set601, set709, coef_sel;
  logic [2:0]       pend_mode, act_mode, eff_mode;
  logic             bypass;

  for (genvar i = 0; i < NCOEF; i++) begin : g_bi
    assign set601[i*COEF_W +: COEF_W] = COEF_W'($signed(BI601[i*BI_W +: BI_W]));
    assign set709[i*COEF_W +: COEF_W] = COEF_W'($signed(BI709[i*BI_W +: BI_W]));
  end

  csc_coef_banks #(.COEF_W(COEF_W), .ADDR_W(ADDR_W), .NCOEF(NCOEF)) u_banks (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .coefs_a(coefs_a), .coefs_b(coefs_b)
  );

  csc_mode_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(6)) u_mode (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .mode_wdata(reg_wdata[2:0]), .frame_start(frame_start),
    .pend_mode(pend_mode), .act_mode(act_mode), .eff_mode(eff_mode)
  );

  always_comb begin
    case (eff_mode)
      MODE_601:    coef_sel = set601;
      MODE_709:    coef_sel = set709;
      MODE_BANK_A: coef_sel = coefs_a;
      MODE_BANK_B: coef_sel = coefs_b;
      default:     coef_sel = '0;
    endcase
  end
  assign bypass = mode_is_bypass(eff_mode);

  csc_datapath #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC),
                 .ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk(clk), .rst(rst), .in_valid(pix_in_valid), .in_pix(pix_in),
    .coefs(coef_sel), .bypass(bypass),
    .out_valid(pix_out_valid), .out_pix(pix_out)
  );

endmodule

// File: rtl/pix_matrix_csc_chk.sv
module pix_matrix_csc_chk #(
  parameter int PIX_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               pix_in_valid,
  input logic [3*PIX_W-1:0] pix_in,
  input logic               pix_out_valid,
  input logic [3*PIX_W-1:0] pix_out,
  input logic [2:0]         pend_mode,
  input logic [2:0]         act_mode,
  input logic [2:0]         eff_mode
);
  logic [1:0] since_rst;
  logic       eff_byp;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign eff_byp = !(eff_mode == 3'd2 || eff_mode == 3'd3 ||
                     eff_mode == 3'd4 || eff_mode == 3'd5);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pix_out_valid); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (pix_out_valid == $past(pix_in_valid, 3))); // R3

  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && pix_out_valid && $past(eff_byp, 3))
      |-> (pix_out == $past(pix_in, 3))); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act_mode)); // R10

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act_mode == $past(pend_mode))); // R10

endmodule

bind pix_matrix_csc pix_matrix_csc_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .pix_in_valid(pix_in_valid), .pix_in(pix_in),
  .pix_out_valid(pix_out_valid), .pix_out(pix_out),
  .pend_mode(pend_mode), .act_mode(act_mode), .eff_mode(eff_mode)
);

// File: tb/pix_matrix_csc_test.sv
module pix_matrix_csc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        frame_start;
  logic        pix_in_valid;
  logic [35:0] pix_in;
  logic        pix_out_valid;
  logic [35:0] pix_out;

  int n_tests = 0;
  int n_fail  = 0;

  int bA [12];
  int bB [12];
  int b601 [12] = '{2449, 4809, 934, 0, -1382, -2714, 4096, 4096, 4096, -3430, -666, 4096};
  int b709 [12] = '{1742, 5859, 591, 0, -939, -3157, 4096, 4096, 4096, -3720, -376, 4096};
  int m_pend = 0;
  int m_act  = 0;

  logic        hv [3];
  logic [35:0] hd [3];
  string       ht [3];

  pix_matrix_csc uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .pix_in_valid(pix_in_valid), .pix_in(pix_in),
    .pix_out_valid(pix_out_valid), .pix_out(pix_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [35:0] model(input int mode, input logic [35:0] p);
    int c [12];
    logic [35:0] r;
    if (!(mode == 2 || mode == 3 || mode == 4 || mode == 5)) return p;
    case (mode)
      2: c = b601;
      3: c = b709;
      4: c = bA;
      default: c = bB;
    endcase
    for (int row = 0; row < 3; row++) begin
      longint s;
      s = longint'(c[row*4])   * longint'(p[11:0]) +
          longint'(c[row*4+1]) * longint'(p[23:12]) +
          longint'(c[row*4+2]) * longint'(p[35:24]) +
          longint'(c[row*4+3]) * 4096 + 4096;
      s = s >>> 13;
      if (s < 0) s = 0;
      if (s > 4095) s = 4095;
      r[row*12 +: 12] = s[11:0];
    end
    return r;
  endfunction

  task automatic step(input logic v, input logic [35:0] p, input logic sof, input string tag);
    if (sof) m_act = m_pend;
    hv[2] = hv[1]; hd[2] = hd[1]; ht[2] = ht[1];
    hv[1] = hv[0]; hd[1] = hd[0]; ht[1] = ht[0];
    hv[0] = v; hd[0] = model(m_act, p); ht[0] = tag;
    pix_in_valid = v;
    pix_in       = p;
    frame_start  = sof;
    @(posedge clk);
    #(CLK_PERIOD/4);
    n_tests++;
    if (pix_out_valid !== hv[2]) begin
      n_fail++;
      $display("FAIL %s: valid act=%0b exp=%0b", ht[2], pix_out_valid, hv[2]);
    end
    if (hv[2]) begin
      n_tests++;
      if (pix_out !== hd[2]) begin
        n_fail++;
        $display("FAIL %s: pix act=%h exp=%h", ht[2], pix_out, hd[2]);
      end
    end
    frame_start = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1'b0, '0, 1'b0, "R3");
    reg_we = 1'b0;
    if (a == 4'd6) m_pend = int'(d[2:0]);
  endtask

  // R4: word k = {coef 2k+1, coef 2k}, bank B at address 8+k
  task automatic load_bank(input bit bank_b, input int c [12]);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] cu, cl;
      cl = c[2*k];
      cu = c[2*k+1];
      wr(bank_b ? 4'(8 + k) : 4'(k), {cu[15:0], cl[15:0]});
    end
    if (bank_b) bB = c; else bA = c;
  endtask

  function automatic logic [35:0] rnd_pix();
    logic [31:0] a, b, c;
    a = $urandom; b = $urandom; c = $urandom;
    return {c[11:0], b[11:0], a[11:0]};
  endfunction

  task automatic run_random(input int n, input bit sof_first, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, rnd_pix(), sof_first && i == 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3: watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_start = 1'b0; pix_in_valid = 1'b0; pix_in = '0;
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hd[i] = '0; ht[i] = "R1"; end
    for (int i = 0; i < 12; i++) begin bA[i] = 0; bB[i] = 0; end
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    n_tests++;
    if (pix_out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid in reset act=%0b exp=0", pix_out_valid);
    end
    rst = 1'b0;

    // R1 / R2: reset mode is bypass
    run_random(300, 1'b1, "R1/R2 bypass after reset");
    // R3: valid with gaps
    for (int i = 0; i < 200; i++) begin
      logic [31:0] g;
      g = $urandom;
      step(g[0], rnd_pix(), 1'b0, "R3 valid gaps");
    end

    // R5: identity in bank A, full sweep of x
    load_bank(1'b0, '{8192, 0, 0, 0, 0, 8192, 0, 0, 0, 0, 8192, 0});
    wr(4'd6, 32'd4);
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] x, y, z;
      x = 12'(i); y = 12'(4095 - i); z = 12'(i * 7);
      step(1'b1, {z, y, x}, i == 0, "R5 identity");
    end

    // R11: load B while A is active
    load_bank(1'b1, '{4096, 4096, 0, 0, -8192, 0, 0, 8192, 16384, 0, 0, -4096});
    run_random(200, 1'b0, "R11 A unchanged during B load");
    // R10: pending B without strobe stays on A
    wr(4'd6, 32'd5);
    run_random(50, 1'b0, "R10 no strobe keeps A");
    // R4/R6/R7: bank B, rounding halves and clamps
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] x, y, z;
      x = 12'(i); y = 12'(i * 13 + 1); z = 12'(4095 - i);
      step(1'b1, {z, y, x}, i == 0, "R4/R6/R7 bank B sweep");
    end

    // R8 / R9: built-in matrices
    wr(4'd6, 32'd2);
    step(1'b1, 36'h0, 1'b1, "R8 601 black");
    step(1'b1, 36'hFFF_FFF_FFF, 1'b0, "R8 601 white");
    run_random(1500, 1'b0, "R8 601");
    wr(4'd6, 32'd3);
    step(1'b1, 36'hFFF_FFF_FFF, 1'b1, "R9 709 white");
    step(1'b1, 36'h000_000_FFF, 1'b0, "R9 709 red");
    run_random(1500, 1'b0, "R9 709");

    // R2: codes 1, 6, 7 behave as bypass
    wr(4'd6, 32'd1); run_random(100, 1'b1, "R2 code 1");
    wr(4'd6, 32'd6); run_random(100, 1'b1, "R2 code 6");
    wr(4'd6, 32'd7); run_random(100, 1'b1, "R2 code 7");

    // R11: bank A kept identity while B was in use
    wr(4'd6, 32'd4);
    run_random(200, 1'b1, "R11 A retained");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, "R3 drain");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule